// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Selectable Write Policies

This block is a direct-mapped cache placed between a processor-side request stream and a word-wide memory stream. Each request names one aligned 32-bit word by byte address. The address is cut into a tag, a line index and a word select. The selected line's valid bit and stored tag decide hit or miss. Lines are kept in registers together with their tag, valid and dirty state. A small state machine handles misses: it writes back a dirty victim, refills the line one word per memory handshake, and then answers the processor.

Two elaboration-time switches set the write behaviour. `WRITE_BACK` selects between writing only into the line (and marking it dirty) and writing memory on every store. `WRITE_ALLOC` selects between refilling a line on a store miss and sending the store straight to memory. The default build holds 16 lines of 4 words on a 16-bit byte address.

Both streams use valid/ready. A side that raises valid keeps valid and its payload unchanged until the handshake cycle. The controller takes one processor request at a time. `req_ready` stays low from acceptance until the response handshake. `rsp_valid` and `rsp_rdata` hold while `rsp_ready` is low. On the memory side, the controller keeps at most one read outstanding. The memory must return read data with `mem_rsp_valid`, which is a single-cycle pulse with no back-pressure, no earlier than the cycle after that read's handshake.

Top module: `dm_cache_ctrl`

## Requirements
- R1: With default parameters, address bits [15:8] are the tag, bits [7:4] select one of 16 lines, bits [3:2] select the word within the line, and bits [1:0] are ignored. Two addresses that differ only in bits [1:0] reach the same word.
- R2: Reset leaves every line invalid and clean, with `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. The first access to any line after reset misses and refills from memory.
- R3: A read whose line is valid and whose tag matches returns the stored word and causes no memory request.
- R4: A read miss issues exactly LINE_WORDS single-word memory reads for the line, from word 0 upward. Only after the last of them does it return the requested word.
- R5: In write-back mode, a write hit updates only the cached word and marks the line dirty. Memory keeps its old value.
- R6: In write-back mode, a miss on a dirty line first writes all LINE_WORDS words of the victim to the victim's address and then refills. A clean victim is replaced with no memory write.
- R7: In write-through mode, every accepted write produces exactly one memory word write to its own address before its response. No line is ever written back.
- R8: In write-allocate mode, a write miss refills the line, merges the written word, and leaves the line valid. Later reads of that word and of its neighbours in the line hit.
- R9: In no-write-allocate mode, a write miss writes that one word to memory and does not fill the line, so a later read of it misses. Read misses still fill.
- R10: Processor side: `req_ready` is low whenever `rsp_valid` is high, and `rsp_valid` with `rsp_rdata` stays unchanged while `rsp_ready` is low.
- R11: Memory side: a raised memory request keeps its address, direction and data until `mem_req_ready`, and no read request is raised while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller accepts a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present (load data or store done) |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_rdata | output | DATA_W | Load data, meaningful for loads only |
| mem_req_valid | output | 1 | Memory word request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | DATA_W | Word to write |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
Two instances run side by side: one in write-back/allocate mode and one in write-through/no-allocate mode. Each runs against a memory model that stalls on a fixed pattern, while the response side is throttled on a different pattern. Cold misses, repeat hits, hits with the two ignored low bits set, and same-line-different-tag conflicts separate correct tag/index decoding from mere data return. Memory read and write counts are measured per access. Memory contents are looked up after stores, to show whether a store stayed in the line, went through, was written back with a dirty victim, or bypassed the line on a miss. A reset in mid-run, followed by a re-read, shows that all lines were invalidated while the written-back data survived in memory.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WRITEBACK = 2'd1,
    ST_REFILL    = 2'd2,
    ST_RESPOND   = 2'd3
  } ctrl_state_e;

endpackage

// File: rtl/cache_addr_fields.sv
module cache_addr_fields #(
  parameter int ADDR_W    = 16,
  parameter int TAG_BITS  = 8,
  parameter int IDX_BITS  = 4,
  parameter int WORD_BITS = 2,
  parameter int BYTE_BITS = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [TAG_BITS-1:0]  tag,
  output logic [IDX_BITS-1:0]  idx,
  output logic [WORD_BITS-1:0] word
);
  logic [BYTE_BITS-1:0] byte_sel_unused;

  assign byte_sel_unused = addr[BYTE_BITS-1:0];
  assign word = addr[BYTE_BITS +: WORD_BITS];
  assign idx  = addr[BYTE_BITS+WORD_BITS +: IDX_BITS];
  assign tag  = addr[ADDR_W-1 -: TAG_BITS];
endmodule

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
  parameter int LINES    = 16,
  parameter int TAG_BITS = 8,
  localparam int IDX_BITS = $clog2(LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic                rd_valid,
  output logic                rd_dirty,
  output logic [TAG_BITS-1:0] rd_tag,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic                wr_valid,
  input  logic                wr_dirty,
  input  logic [TAG_BITS-1:0] wr_tag
);
  logic [LINES-1:0]    valid_q;
  logic [LINES-1:0]    dirty_q;
  logic [TAG_BITS-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cache_data_array.sv
module cache_data_array #(
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_BITS  = $clog2(LINES),
  localparam int WORD_BITS = $clog2(LINE_WORDS)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IDX_BITS-1:0]  wr_idx,
  input  logic [WORD_BITS-1:0] wr_word,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [IDX_BITS-1:0]  a_idx,
  input  logic [WORD_BITS-1:0] a_word,
  output logic [DATA_W-1:0]    a_data,
  input  logic [IDX_BITS-1:0]  b_idx,
  input  logic [WORD_BITS-1:0] b_word,
  output logic [DATA_W-1:0]    b_data
);
  logic [DATA_W-1:0] store_q [LINES][LINE_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx][wr_word] <= wr_data;
  end

  assign a_data = store_q[a_idx][a_word];
  assign b_data = store_q[b_idx][b_word];
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LINES       = 16,
  parameter int LINE_WORDS  = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam int BYTE_BITS = $clog2(DATA_W / 8);
  localparam int WORD_BITS = $clog2(LINE_WORDS);
  localparam int IDX_BITS  = $clog2(LINES);
  localparam int TAG_BITS  = ADDR_W - IDX_BITS - WORD_BITS - BYTE_BITS;
  localparam logic [WORD_BITS-1:0] LAST_BEAT = WORD_BITS'(LINE_WORDS - 1);
  localparam logic [BYTE_BITS-1:0] NO_BYTE   = '0;

  ctrl_state_e state;

  logic [TAG_BITS-1:0]  in_tag;
  logic [IDX_BITS-1:0]  in_idx;
  logic [WORD_BITS-1:0] in_word;

  logic                 cur_write;
  logic [TAG_BITS-1:0]  cur_tag;
  logic [IDX_BITS-1:0]  cur_idx;
  logic [WORD_BITS-1:0] cur_word;
  logic [DATA_W-1:0]    cur_wdata;
  logic [TAG_BITS-1:0]  victim_tag;
  logic [WORD_BITS-1:0] beat;
  logic                 rd_wait;
  logic                 mem_wr_pend;
  logic [DATA_W-1:0]    rsp_data_q;

  logic                 line_valid, line_dirty;
  logic [TAG_BITS-1:0]  line_tag;
  logic                 hit;
  logic                 accept;
  logic                 fill_beat;

  logic                 tag_we, tag_wvalid, tag_wdirty;
  logic [IDX_BITS-1:0]  tag_widx;
  logic [TAG_BITS-1:0]  tag_wtag;

  logic                 dat_we;
  logic [IDX_BITS-1:0]  dat_widx;
  logic [WORD_BITS-1:0] dat_wword;
  logic [DATA_W-1:0]    dat_wdata;
  logic [DATA_W-1:0]    hit_word, victim_word;

  cache_addr_fields #(
    .ADDR_W(ADDR_W), .TAG_BITS(TAG_BITS), .IDX_BITS(IDX_BITS),
    .WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS)
  ) u_fields (
    .addr(req_addr), .tag(in_tag), .idx(in_idx), .word(in_word)
  );

  cache_tag_array #(.LINES(LINES), .TAG_BITS(TAG_BITS)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(in_idx), .rd_valid(line_valid), .rd_dirty(line_dirty), .rd_tag(line_tag),
    .wr_en(tag_we), .wr_idx(tag_widx), .wr_valid(tag_wvalid),
    .wr_dirty(tag_wdirty), .wr_tag(tag_wtag)
  );

  cache_data_array #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .wr_en(dat_we), .wr_idx(dat_widx), .wr_word(dat_wword), .wr_data(dat_wdata),
    .a_idx(in_idx), .a_word(in_word), .a_data(hit_word),
    .b_idx(cur_idx), .b_word(beat), .b_data(victim_word)
  );

  assign hit       = line_valid && (line_tag == in_tag);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign fill_beat = (state == ST_REFILL) && rd_wait && mem_rsp_valid;
  assign rsp_valid = (state == ST_RESPOND) && !mem_wr_pend;
  assign rsp_rdata = rsp_data_q;

  // Tag-state updates: dirty marking on a write-back hit, line install at fill end.
  always_comb begin
    tag_we     = 1'b0;
    tag_widx   = cur_idx;
    tag_wvalid = 1'b1;
    tag_wdirty = 1'b0;
    tag_wtag   = cur_tag;
    if (accept && hit && req_write && WRITE_BACK) begin
      tag_we     = 1'b1;
      tag_widx   = in_idx;
      tag_wdirty = 1'b1;
      tag_wtag   = in_tag;
    end else if (fill_beat && beat == LAST_BEAT) begin
      tag_we     = 1'b1;
      tag_wdirty = cur_write && WRITE_BACK;
    end
  end

  // Data updates: write hit, or each refill beat with the pending store merged in.
  always_comb begin
    dat_we    = 1'b0;
    dat_widx  = cur_idx;
    dat_wword = beat;
    dat_wdata = mem_rsp_rdata;
    if (accept && hit && req_write) begin
      dat_we    = 1'b1;
      dat_widx  = in_idx;
      dat_wword = in_word;
      dat_wdata = req_wdata;
    end else if (fill_beat) begin
      dat_we = 1'b1;
      if (cur_write && beat == cur_word) dat_wdata = cur_wdata;
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = {cur_tag, cur_idx, beat, NO_BYTE};
    mem_req_wdata = cur_wdata;
    unique case (state)
      ST_WRITEBACK: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {victim_tag, cur_idx, beat, NO_BYTE};
        mem_req_wdata = victim_word;
      end
      ST_REFILL: mem_req_valid = !rd_wait;
      ST_RESPOND: begin
        mem_req_valid = mem_wr_pend;
        mem_req_write = 1'b1;
        mem_req_addr  = {cur_tag, cur_idx, cur_word, NO_BYTE};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_write   <= 1'b0;
      cur_tag     <= '0;
      cur_idx     <= '0;
      cur_word    <= '0;
      cur_wdata   <= '0;
      victim_tag  <= '0;
      beat        <= '0;
      rd_wait     <= 1'b0;
      mem_wr_pend <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          cur_write   <= req_write;
          cur_tag     <= in_tag;
          cur_idx     <= in_idx;
          cur_word    <= in_word;
          cur_wdata   <= req_wdata;
          victim_tag  <= line_tag;
          beat        <= '0;
          rd_wait     <= 1'b0;
          mem_wr_pend <= 1'b0;
          if (hit) begin
            if (!req_write) rsp_data_q <= hit_word;
            mem_wr_pend <= req_write && !WRITE_BACK;
            state       <= ST_RESPOND;
          end else if (req_write && !WRITE_ALLOC) begin
            mem_wr_pend <= 1'b1;
            state       <= ST_RESPOND;
          end else if (WRITE_BACK && line_valid && line_dirty) begin
            state <= ST_WRITEBACK;
          end else begin
            state <= ST_REFILL;
          end
        end
        ST_WRITEBACK: if (mem_req_ready) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) state <= ST_REFILL;
        end
        ST_REFILL: begin
          if (!rd_wait) begin
            if (mem_req_ready) rd_wait <= 1'b1;
          end else if (mem_rsp_valid) begin
            rd_wait <= 1'b0;
            beat    <= beat + 1'b1;
            if (!cur_write && beat == cur_word) rsp_data_q <= mem_rsp_rdata;
            if (beat == LAST_BEAT) begin
              mem_wr_pend <= cur_write && !WRITE_BACK;
              state       <= ST_RESPOND;
            end
          end
        end
        ST_RESPOND: begin
          if (mem_wr_pend) begin
            if (mem_req_ready) mem_wr_pend <= 1'b0;
          end else if (rsp_ready) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_ctrl_checker.sv
module cache_ctrl_checker #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid
);
  logic       acc_write;
  logic       rd_out;
  logic [7:0] wr_cnt, rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_write <= 1'b0;
      rd_out    <= 1'b0;
      wr_cnt    <= '0;
      rd_cnt    <= '0;
    end else begin
      if (req_valid && req_ready) begin
        acc_write <= req_write;
        wr_cnt    <= '0;
        rd_cnt    <= '0;
      end else if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) wr_cnt <= wr_cnt + 8'd1;
        else               rd_cnt <= rd_cnt + 8'd1;
      end
      if (mem_req_valid && mem_req_ready && !mem_req_write) rd_out <= 1'b1;
      else if (mem_rsp_valid)                               rd_out <= 1'b0;
    end
  end

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_one_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> !rd_out);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_fill_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rd_cnt == 8'd0 || rd_cnt == 8'(LINE_WORDS)));

  generate
    if (WRITE_BACK) begin : g_wb
      assert_evict_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !acc_write |-> (wr_cnt == 8'd0 || wr_cnt == 8'(LINE_WORDS)));
    end else begin : g_wt
      assert_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> wr_cnt == (acc_write ? 8'd1 : 8'd0));
    end
  endgenerate
endmodule

bind dm_cache_ctrl cache_ctrl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .WRITE_BACK(WRITE_BACK)
) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/cache_mem_model.sv
module cache_mem_model #(
  parameter int STALL_MOD = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic [15:0] peek_addr,
  output logic [31:0] peek_data,
  output int          wr_count,
  output int          rd_count,
  output logic [15:0] last_rd_addr
);
  logic [31:0] store [logic [13:0]];
  int cyc = 0;

  function automatic logic [31:0] init_word(logic [13:0] w);
    return {16'hC0DE ^ {2'b00, w}, 2'b00, w};
  endfunction

  function automatic logic [31:0] fetch(logic [13:0] w);
    if (store.exists(w)) return store[w];
    return init_word(w);
  endfunction

  initial begin
    wr_count = 0;
    rd_count = 0;
    last_rd_addr = '0;
    rsp_valid = 1'b0;
    rsp_rdata = '0;
  end

  assign req_ready = (cyc % STALL_MOD) != 0;
  always_comb peek_data = fetch(peek_addr[15:2]);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid <= 1'b0;
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (req_valid && req_ready) begin
      if (req_write) begin
        store[req_addr[15:2]] = req_wdata;
        wr_count = wr_count + 1;
      end else begin
        rsp_valid <= 1'b1;
        rsp_rdata <= fetch(req_addr[15:2]);
        rd_count = rd_count + 1;
        last_rd_addr = req_addr;
      end
    end
  end
endmodule

// File: tb/dm_cache_ctrl_bench.sv
module dm_cache_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          wr;
    logic [31:0] exp;
    string       name;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Two instances: [0] write-back + allocate, [1] write-through + no allocate.
  logic        req_valid [2];
  logic        req_ready [2];
  logic        req_write [2];
  logic [15:0] req_addr  [2];
  logic [31:0] req_wdata [2];
  logic        rsp_valid [2];
  logic        rsp_ready [2];
  logic [31:0] rsp_rdata [2];
  logic        m_valid [2], m_ready [2], m_write [2], m_rvalid [2];
  logic [15:0] m_addr [2];
  logic [31:0] m_wdata [2], m_rdata [2];
  logic [15:0] peek_addr [2];
  logic [31:0] peek_data [2];
  int          wr_count [2], rd_count [2];
  logic [15:0] last_rd [2];

  item_t q_a[$];
  item_t q_b[$];
  logic [31:0] gold [logic [13:0]];

  dm_cache_ctrl #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) u_dm_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]), .rsp_rdata(rsp_rdata[0]),
    .mem_req_valid(m_valid[0]), .mem_req_ready(m_ready[0]), .mem_req_write(m_write[0]),
    .mem_req_addr(m_addr[0]), .mem_req_wdata(m_wdata[0]),
    .mem_rsp_valid(m_rvalid[0]), .mem_rsp_rdata(m_rdata[0])
  );

  dm_cache_ctrl #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) u_dm_cache_ctrl_wt (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]), .rsp_rdata(rsp_rdata[1]),
    .mem_req_valid(m_valid[1]), .mem_req_ready(m_ready[1]), .mem_req_write(m_write[1]),
    .mem_req_addr(m_addr[1]), .mem_req_wdata(m_wdata[1]),
    .mem_rsp_valid(m_rvalid[1]), .mem_rsp_rdata(m_rdata[1])
  );

  cache_mem_model #(.STALL_MOD(3)) u_mem_a (
    .clk(clk), .rst_n(rst_n), .req_valid(m_valid[0]), .req_ready(m_ready[0]),
    .req_write(m_write[0]), .req_addr(m_addr[0]), .req_wdata(m_wdata[0]),
    .rsp_valid(m_rvalid[0]), .rsp_rdata(m_rdata[0]),
    .peek_addr(peek_addr[0]), .peek_data(peek_data[0]),
    .wr_count(wr_count[0]), .rd_count(rd_count[0]), .last_rd_addr(last_rd[0])
  );

  cache_mem_model #(.STALL_MOD(4)) u_mem_b (
    .clk(clk), .rst_n(rst_n), .req_valid(m_valid[1]), .req_ready(m_ready[1]),
    .req_write(m_write[1]), .req_addr(m_addr[1]), .req_wdata(m_wdata[1]),
    .rsp_valid(m_rvalid[1]), .rsp_rdata(m_rdata[1]),
    .peek_addr(peek_addr[1]), .peek_data(peek_data[1]),
    .wr_count(wr_count[1]), .rd_count(rd_count[1]), .last_rd_addr(last_rd[1])
  );

  function automatic logic [31:0] init_word(logic [13:0] w);
    return {16'hC0DE ^ {2'b00, w}, 2'b00, w};
  endfunction

  function automatic logic [31:0] gold_read(logic [15:0] a);
    if (gold.exists(a[15:2])) return gold[a[15:2]];
    return init_word(a[15:2]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int q_size(int sel);
    return (sel == 0) ? q_a.size() : q_b.size();
  endfunction

  // Scoreboard monitor: pops one expected item per response handshake.
  task automatic consume(int sel);
    item_t it;
    if (q_size(sel) == 0) begin
      check("R10 unexpected response", 32'd1, 32'd0);
      return;
    end
    it = (sel == 0) ? q_a.pop_front() : q_b.pop_front();
    check("R10 req_ready low during response", {31'd0, req_ready[sel]}, 32'd0);
    if (!it.wr) check(it.name, rsp_rdata[sel], it.exp);
  endtask

  for (genvar g = 0; g < 2; g++) begin : g_mon
    initial begin
      rsp_ready[g] = 1'b1;
      forever begin
        @(negedge clk);
        rsp_ready[g] = (g == 0) ? ((cyc % 4) != 1) : ((cyc % 5) != 2);
        #1;
        if (rst_n && rsp_valid[g] && rsp_ready[g]) consume(g);
      end
    end
  end

  // Driver: pushes the expected item, then offers the request until taken.
  task automatic cpu_access(int sel, bit wr, logic [15:0] addr, logic [31:0] data, string name);
    item_t it;
    bit taken;
    it.wr = wr;
    it.exp = gold_read(addr);
    it.name = name;
    if (sel == 0) q_a.push_back(it); else q_b.push_back(it);
    if (wr) gold[addr[15:2]] = data;
    @(negedge clk);
    req_valid[sel] = 1'b1;
    req_write[sel] = wr;
    req_addr[sel]  = addr;
    req_wdata[sel] = data;
    forever begin
      taken = req_ready[sel];
      @(negedge clk);
      if (taken) break;
    end
    req_valid[sel] = 1'b0;
  endtask

  task automatic access_sync(int sel, bit wr, logic [15:0] addr, logic [31:0] data,
                             string name, output int d_rd, output int d_wr);
    int rd0, wr0;
    rd0 = rd_count[sel];
    wr0 = wr_count[sel];
    cpu_access(sel, wr, addr, data, name);
    while (q_size(sel) != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    d_rd = rd_count[sel] - rd0;
    d_wr = wr_count[sel] - wr0;
  endtask

  task automatic peek(int sel, logic [15:0] addr, string name, logic [31:0] exp);
    peek_addr[sel] = addr;
    #1;
    check(name, peek_data[sel], exp);
  endtask

  task automatic check_reset_state(string name);
    for (int s = 0; s < 2; s++) begin
      check({name, " req_ready"}, {31'd0, req_ready[s]}, 32'd1);
      check({name, " rsp_valid"}, {31'd0, rsp_valid[s]}, 32'd0);
      check({name, " mem_req_valid"}, {31'd0, m_valid[s]}, 32'd0);
    end
  endtask

  localparam logic [15:0] A  = 16'h1014;  // tag 10, line 1, word 1
  localparam logic [15:0] A2 = 16'h1018;  // same line, word 2
  localparam logic [15:0] B  = 16'h2014;  // tag 20, line 1
  localparam logic [15:0] C  = 16'h3028;  // tag 30, line 2, word 2
  localparam logic [15:0] CN = 16'h3024;  // same line, word 1
  localparam logic [15:0] D  = 16'h4024;  // tag 40, line 2
  localparam logic [15:0] E  = 16'h5034;  // tag 50, line 3
  localparam logic [15:0] F  = 16'h6034;  // tag 60, line 3

  initial begin
    int drd, dwr;
    for (int s = 0; s < 2; s++) begin
      req_valid[s] = 1'b0; req_write[s] = 1'b0;
      req_addr[s] = '0; req_wdata[s] = '0; peek_addr[s] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R2 reset");

    // Write-back / allocate instance
    access_sync(0, 0, A, 0, "R2 R4 cold read data", drd, dwr);
    check("R4 cold read fetch count", drd, 4);
    check("R4 cold read write count", dwr, 0);
    check("R4 last refill address", {16'd0, last_rd[0]}, 32'h101C);
    access_sync(0, 0, A2, 0, "R3 hit data", drd, dwr);
    check("R3 hit traffic", drd + dwr, 0);
    access_sync(0, 0, A | 16'h0002, 0, "R1 low bits ignored data", drd, dwr);
    check("R1 low bits hit traffic", drd + dwr, 0);
    access_sync(0, 1, A, 32'hDEAD0001, "R5 write hit", drd, dwr);
    check("R5 write hit traffic", drd + dwr, 0);
    peek(0, A, "R5 memory untouched", init_word(A[15:2]));
    access_sync(0, 0, A, 0, "R5 read after write", drd, dwr);
    access_sync(0, 0, B, 0, "R1 R6 conflict read data", drd, dwr);
    check("R6 dirty eviction writes", dwr, 4);
    check("R6 dirty eviction refill", drd, 4);
    peek(0, A, "R6 written back value", 32'hDEAD0001);
    access_sync(0, 0, A, 0, "R6 reload after eviction", drd, dwr);
    check("R6 clean eviction writes", dwr, 0);
    access_sync(0, 1, C, 32'hCAFE0002, "R8 write miss", drd, dwr);
    check("R8 allocate refill", drd, 4);
    check("R8 allocate no write", dwr, 0);
    access_sync(0, 0, C, 0, "R8 read merged word", drd, dwr);
    check("R8 merged word hits", drd, 0);
    access_sync(0, 0, CN, 0, "R8 neighbour word", drd, dwr);
    check("R8 neighbour hits", drd, 0);
    access_sync(0, 1, D, 32'hBEEF0003, "R6 write on dirty line", drd, dwr);
    check("R6 dirty allocated line writes", dwr, 4);
    peek(0, C, "R6 allocated store written back", 32'hCAFE0002);

    // Write-through / no-allocate instance
    access_sync(1, 1, E, 32'h11110004, "R9 write miss", drd, dwr);
    check("R9 R7 miss single write", dwr, 1);
    check("R9 no fill on write miss", drd, 0);
    peek(1, E, "R9 memory updated", 32'h11110004);
    access_sync(1, 0, E, 0, "R9 read after write miss", drd, dwr);
    check("R9 read still misses", drd, 4);
    access_sync(1, 1, E, 32'h22220005, "R7 write hit", drd, dwr);
    check("R7 write hit single write", dwr, 1);
    check("R7 write hit no read", drd, 0);
    peek(1, E, "R7 memory follows", 32'h22220005);
    access_sync(1, 0, E, 0, "R7 cached copy updated", drd, dwr);
    check("R7 read hits", drd, 0);
    access_sync(1, 0, F, 0, "R7 conflict read", drd, dwr);
    check("R7 no line writeback", dwr, 0);

    // Mid-run reset invalidates lines; memory keeps written-back data.
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R2 second reset");
    access_sync(0, 0, A, 0, "R2 data after reset", drd, dwr);
    check("R2 line invalid after reset", drd, 4);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule